// File: doc/BRIEF.md
# Serial Frame Sync Error Detector

This block watches a three-wire serial shift port: a data line, a shift clock and a load strobe. All three arrive without any timing relation to the system clock. Each one passes through a two-flop synchronizer, and edges are detected on the synchronized copies. The block counts shift-clock rising edges in the current frame. It raises a sticky out-of-sync flag when the load strobe comes at a bad moment. A bad moment is either before a full frame of `FRAME_LEN` clocks has arrived, or while the shift clock is high. Every strobe returns the serial interface to its idle state.

On the first shift-clock rising edge after a strobe, the block loads an outgoing status frame and starts shifting it out. The frame carries the out-of-sync flag gathered since the previous capture, followed by one field per channel. In each field, zero padding comes before a value taken from `stat_vals_i`. The accumulator clears at that capture, so each report covers exactly one window. A window runs from one first-of-frame clock edge to the next. The block also keeps the most recent received data bits for use by neighbouring logic.

Top module: `frame_sync_monitor`

## Requirements
- R1: After reset, `frame_err_o`, `sdo_o` and `rx_data_o` are all zero.
- R2: A strobe that arrives when the bit count is between 1 and `FRAME_LEN`-1 sets `frame_err_o`.
- R3: A strobe that arrives while the synchronized shift clock is high sets `frame_err_o`, even when the count is full.
- R4: A strobe that arrives with the shift clock low and a count of 0 or exactly `FRAME_LEN` leaves the flag unchanged. This covers repeated strobes with no clocks between them. The count saturates at `FRAME_LEN`, so surplus clocks are never taken as early.
- R5: Every strobe clears the bit count, `rx_data_o` and the outgoing shift register, so `sdo_o` reads 0.
- R6: The first shift-clock rise after a strobe (or after reset) loads the status frame. Its first bit, visible on `sdo_o` after that rise, is the flag value held just before the rise. The flag then clears.
- R7: The status frame is sent MSB first, one bit per rise. Bit 0 is the flag. Then come `NCH` fields, channel 0 first. Each field is `PAD_W` zero bits followed by `stat_vals_i[c*VAL_W +: VAL_W]`, most significant bit first. Every later bit in the frame reads 0.
- R8: On each shift-clock rise, `rx_data_o` shifts left and takes the sampled data bit into bit 0.
- R9: Once set, the flag holds through further strobes until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Asynchronous shift clock |
| ld_i | input | 1 | Asynchronous load strobe |
| sdi_i | input | 1 | Asynchronous serial data in |
| stat_vals_i | input | NCH*VAL_W | Per-channel status values, sampled at capture |
| sdo_o | output | 1 | Status frame serial out |
| frame_err_o | output | 1 | Live out-of-sync accumulator |
| rx_data_o | output | RX_W | Most recent received bits, newest in bit 0 |

## Verification
The bench builds the block with `FRAME_LEN`=24, `NCH`=2, `PAD_W`=5, `VAL_W`=3 and `RX_W`=8. A full frame therefore takes only a few hundred system clocks. Runs of up to 32 shift clocks reach count saturation. The 17-bit status frame is short enough that its trailing zero bits show within every full frame. Directed cases cover strobes at counts 1, `FRAME_LEN`-1, exactly `FRAME_LEN` and above it, a strobe during the final high phase, and back-to-back strobes. Random frame lengths and data fill in the space between these cases.

// File: rtl/frame_mon_pkg.sv
package frame_mon_pkg;
  function automatic int stat_len(input int nch, input int pad_w, input int val_w);
    return 1 + nch * (pad_w + val_w);
  endfunction
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fm_frame_ctl.sv
module fm_frame_ctl #(
  parameter int FRAME_LEN = 584,
  localparam int CW = $clog2(FRAME_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_lvl_i,
  input  logic          sck_rise_i,
  input  logic          ld_rise_i,
  output logic [CW-1:0] cnt_o,
  output logic          capture_o,
  output logic          err_o
);
  localparam logic [CW-1:0] FULL = CW'(FRAME_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_q, first_d;
  logic          err_q, err_d;
  logic          early;

  assign early     = (cnt_q != '0) && (cnt_q < FULL);
  assign capture_o = sck_rise_i && !ld_rise_i && first_q;

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    err_d   = err_q;
    if (ld_rise_i) begin
      cnt_d   = '0;
      first_d = 1'b1;
      if (sck_lvl_i || early) err_d = 1'b1;
    end else if (sck_rise_i) begin
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      if (first_q) begin
        first_d = 1'b0;
        err_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/fm_stat_tx.sv
module fm_stat_tx #(
  parameter int NCH   = 48,
  parameter int PAD_W = 5,
  parameter int VAL_W = 6,
  localparam int FW = PAD_W + VAL_W,
  localparam int SL = frame_mon_pkg::stat_len(NCH, PAD_W, VAL_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic               flag_i,
  input  logic [NCH*VAL_W-1:0] vals_i,
  output logic               sdo_o
);
  logic [SL-1:0] img;
  logic [SL-1:0] sr_q, sr_d;

  always_comb begin
    img       = '0;
    img[SL-1] = flag_i;
    for (int c = 0; c < NCH; c++) begin
      for (int b = 0; b < VAL_W; b++) begin
        img[(NCH-1-c)*FW + b] = vals_i[c*VAL_W + b];
      end
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (clear_i)      sr_d = '0;
    else if (load_i)  sr_d = img;
    else if (shift_i) sr_d = {sr_q[SL-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sdo_o = sr_q[SL-1];
endmodule

// File: rtl/fm_rx_shift.sv
module fm_rx_shift #(
  parameter int RX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [RX_W-1:0] data_o
);
  logic [RX_W-1:0] rx_q, rx_d;

  always_comb begin
    rx_d = rx_q;
    if (clear_i)      rx_d = '0;
    else if (shift_i) rx_d = {rx_q[RX_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign data_o = rx_q;
endmodule

// File: rtl/frame_sync_monitor.sv
module frame_sync_monitor #(
  parameter int FRAME_LEN = 584,
  parameter int NCH       = 48,
  parameter int PAD_W     = 5,
  parameter int VAL_W     = 6,
  parameter int RX_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_i,
  input  logic                 ld_i,
  input  logic                 sdi_i,
  input  logic [NCH*VAL_W-1:0] stat_vals_i,
  output logic                 sdo_o,
  output logic                 frame_err_o,
  output logic [RX_W-1:0]      rx_data_o
);
  localparam int CW = $clog2(FRAME_LEN + 1);

  logic [1:0]    rst_pipe_q;
  logic          rst_n_sync;
  logic [2:0]    sync_lvl;
  logic          sck_lvl, ld_lvl, sdi_lvl;
  logic          sck_prev_q, ld_prev_q;
  logic          sck_rise, ld_rise;
  logic [CW-1:0] bit_cnt;
  logic          capture;
  logic          err_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  fm_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d_i   ({sck_i, ld_i, sdi_i}),
    .q_o   (sync_lvl)
  );
  assign {sck_lvl, ld_lvl, sdi_lvl} = sync_lvl;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      sck_prev_q <= 1'b0;
      ld_prev_q  <= 1'b0;
    end else begin
      sck_prev_q <= sck_lvl;
      ld_prev_q  <= ld_lvl;
    end
  end
  assign sck_rise = sck_lvl & ~sck_prev_q;
  assign ld_rise  = ld_lvl & ~ld_prev_q;

  fm_frame_ctl #(.FRAME_LEN(FRAME_LEN)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .sck_lvl_i  (sck_lvl),
    .sck_rise_i (sck_rise),
    .ld_rise_i  (ld_rise),
    .cnt_o      (bit_cnt),
    .capture_o  (capture),
    .err_o      (err_acc)
  );

  fm_stat_tx #(.NCH(NCH), .PAD_W(PAD_W), .VAL_W(VAL_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .clear_i (ld_rise),
    .load_i  (capture),
    .shift_i (sck_rise),
    .flag_i  (err_acc),
    .vals_i  (stat_vals_i),
    .sdo_o   (sdo_o)
  );

  fm_rx_shift #(.RX_W(RX_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .clear_i (ld_rise),
    .shift_i (sck_rise),
    .bit_i   (sdi_lvl),
    .data_o  (rx_data_o)
  );

  assign frame_err_o = err_acc;
endmodule

// File: rtl/frame_mon_chk.sv
module frame_mon_chk #(
  parameter int FRAME_LEN = 584,
  parameter int RX_W      = 8,
  localparam int CW = $clog2(FRAME_LEN + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sck_lvl,
  input logic            sck_rise,
  input logic            ld_rise,
  input logic            sdi_lvl,
  input logic [CW-1:0]   cnt,
  input logic            err,
  input logic            sdo,
  input logic [RX_W-1:0] rx
);
  localparam logic [CW-1:0] FULL = CW'(FRAME_LEN);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R4
  AST_LD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> (cnt == '0 && rx == '0 && !sdo)); // R5
  AST_EARLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && cnt != '0 && cnt < FULL) |=> err); // R2
  AST_HIGH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && sck_lvl) |=> err); // R3
  AST_REPEAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && cnt == '0 && !sck_lvl && !err) |=> !err); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !sck_rise) |=> err); // R9
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !ld_rise && cnt == '0) |=> (!err && sdo == $past(err))); // R6
  AST_RX_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !ld_rise) |=> rx[0] == $past(sdi_lvl)); // R8
endmodule

bind frame_sync_monitor frame_mon_chk #(.FRAME_LEN(FRAME_LEN), .RX_W(RX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .sck_lvl  (sck_lvl),
  .sck_rise (sck_rise),
  .ld_rise  (ld_rise),
  .sdi_lvl  (sdi_lvl),
  .cnt      (bit_cnt),
  .err      (err_acc),
  .sdo      (sdo_o),
  .rx       (rx_data_o)
);

// File: tb/sim_frame_sync_monitor.sv
module sim_frame_sync_monitor;
  localparam int FL    = 24;
  localparam int NCH   = 2;
  localparam int PAD_W = 5;
  localparam int VAL_W = 3;
  localparam int RX_W  = 8;
  localparam int FW    = PAD_W + VAL_W;
  localparam int SL    = 1 + NCH * FW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ld = 1'b0, sdi = 1'b0;
  logic [NCH*VAL_W-1:0] vals = '0;
  logic sdo, ferr;
  logic [RX_W-1:0] rx;

  int total = 0, bad = 0;
  bit done = 1'b0;

  int m_cnt = 0, m_pos = 0;
  bit m_first = 1'b1, m_acc = 1'b0, m_flag = 1'b0;
  logic [RX_W-1:0] m_rx = '0;
  logic [NCH*VAL_W-1:0] m_vals = '0;

  always #2 clk = ~clk;

  frame_sync_monitor #(.FRAME_LEN(FL), .NCH(NCH), .PAD_W(PAD_W), .VAL_W(VAL_W), .RX_W(RX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ld_i(ld), .sdi_i(sdi),
    .stat_vals_i(vals), .sdo_o(sdo), .frame_err_o(ferr), .rx_data_o(rx)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int pos);
    int k, c, p;
    if (pos == 0) return m_flag;
    if (pos >= SL) return 1'b0;
    k = pos - 1; c = k / FW; p = k % FW;
    if (p < PAD_W) return 1'b0;
    return m_vals[c*VAL_W + (VAL_W - 1 - (p - PAD_W))];
  endfunction

  task automatic strobe();
    if (sck || (m_cnt > 0 && m_cnt < FL)) m_acc = 1'b1;
    m_cnt = 0; m_first = 1'b1; m_rx = '0;
    ld = 1'b1; wait_clk(6);
    ld = 1'b0; wait_clk(6);
    check("R2/R3/R4/R9 flag after strobe", ferr, m_acc);
    check("R5 rx cleared", rx, m_rx);
    check("R5 sdo cleared", sdo, 1'b0);
  endtask

  task automatic pulse(input logic b, input bit ld_high);
    sdi = b; wait_clk(3);
    sck = 1'b1; wait_clk(6);
    if (m_first) begin
      m_flag = m_acc; m_acc = 1'b0; m_first = 1'b0; m_pos = 0; m_vals = vals;
    end else m_pos++;
    if (m_cnt < FL) m_cnt++;
    m_rx = {m_rx[RX_W-2:0], b};
    check("R6/R7 sdo bit", sdo, exp_bit(m_pos));
    check("R8 rx shift", rx, m_rx);
    check("R6 flag after capture", ferr, m_acc);
    if (ld_high) strobe();
    sck = 1'b0; wait_clk(6);
  endtask

  task automatic frame(input int len, input bit hi);
    for (int i = 0; i < len; i++) pulse(1'($urandom), hi && (i == len - 1));
    if (!hi) strobe();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd77);
    wait_clk(5); rst_n = 1'b1; wait_clk(8);
    check("R1 reset err", ferr, 1'b0);
    check("R1 reset sdo", sdo, 1'b0);
    check("R1 reset rx", rx, '0);
    vals = 6'b101_011;
    frame(FL, 1'b0);          // R4 exact length, no flag
    strobe();                 // R4 repeated strobe
    frame(FL - 1, 1'b0);      // R2 one short
    strobe();                 // R9 flag stays
    vals = 6'b010_111;
    frame(FL + 8, 1'b0);      // R6 flag reported, R4 saturation
    frame(FL, 1'b1);          // R3 strobe while high
    frame(1, 1'b0);           // R2 count of one
    frame(FL, 1'b0);
    for (int f = 0; f < 40; f++) begin
      vals = NCH*VAL_W'($urandom);
      frame(($urandom % 4 == 0) ? FL : 1 + int'($urandom % (FL + 8)), ($urandom % 3) == 0);
      if ($urandom % 5 == 0) strobe();
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule